// File: doc/BRIEF.md
# Voted Branch Clock Gate

This block is a branch gate that sits after a root clock generator. It receives that generator's clock-enable pulse stream and passes it on to one consumer. The gate opens when any of three sources asks for it: a software enable, an external hardware request (only when hardware control is switched on), or any vote bit that is allowed through the vote mask in a shared vote register. An integer post-divider packed into the control register can thin the passed stream to one pulse in every N+1.

A read-only halted flag tells software the real gate state. It follows the effective enable after a fixed settling delay, so a driver polls it after turning the branch on or off. A separate block-reset register drives a reset output for the consumer logic. While that output is asserted, the gate is held closed.

The register bus has a single-cycle write strobe, a two-bit address and a combinational read data path. Address 0 is control, address 1 is block reset, address 2 is the vote register, and address 3 reads as zero.

Top module: `bcg_branch`

## Requirements
- R1: With control bit 0 set, the gate is open and ce_out equals ce_in (post-divider field 0).
- R2: The hw_req input opens the gate only while control bit 1 is set. Without bit 1, hw_req has no effect on ce_out.
- R3: The vote register (address 2, one bit per voter) is ANDed with VOTE_MASK. Any nonzero masked bit opens the gate, and clearing one vote while another masked vote remains keeps it open. Votes outside the mask have no effect.
- R4: Control bits 24:16 hold the post-divider value N. With N=0 every enabled ce_in pulse passes. With N>0 only every (N+1)-th enabled ce_in pulse passes.
- R5: A control write whose bits 24:16 exceed MAX_DIV leaves the divider field unchanged, while bits 0 and 1 of that write still take effect. A value equal to MAX_DIV is accepted.
- R6: An accepted change of the divider value clears the pulse count, so the first output after the change comes on the (N+1)-th enabled input pulse.
- R7: Control bit 31 reads 1 when the branch is halted. It reads 0 exactly 3 clock cycles after the effective enable rises, and returns to 1 exactly 3 cycles after the effective enable falls.
- R8: Bit 0 of the block-reset register (address 1) drives blk_rst_out while it is 1.
- R9: While the block reset is asserted, ce_out is 0 and bit 31 reads 1 at once. Control, vote and divider contents are kept.
- R10: After rst_n, control reads 32'h8000_0000, the block-reset and vote registers read 0, blk_rst_out is 0 and ce_out is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select: 0 control, 1 block reset, 2 vote |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| ce_in | input | 1 | Clock-enable pulses from the root generator |
| hw_req | input | 1 | Hardware gate request |
| ce_out | output | 1 | Gated and divided clock-enable pulses |
| blk_rst_out | output | 1 | Block reset to the consumer |

## Verification
The bench looks for a masked voter that still opens the gate, and for a gate that closes when one of two votes is withdrawn. It checks that a divider change leaves a short first period when the count is not cleared, and that an oversize divider write is stored, or drops the enable bits written with it. It times the halted flag in both directions, since a design off by one stage would report the gate state one cycle early or late. It also confirms that the block reset closes the gate and raises the halted flag without clearing the registers.

// File: rtl/bcg_pkg.sv
`timescale 1ns/1ps
package bcg_pkg;
   typedef enum logic [1:0] {
      REG_CTRL = 2'd0,
      REG_BRST = 2'd1,
      REG_VOTE = 2'd2
   } reg_sel_e;

   localparam int CTRL_SW_BIT  = 0;
   localparam int CTRL_HW_BIT  = 1;
   localparam int CTRL_DIV_LSB = 16;
   localparam int CTRL_DIV_W   = 9;
   localparam int CTRL_OFF_BIT = 31;
endpackage

// File: rtl/bcg_regs.sv
`timescale 1ns/1ps
module bcg_regs
   import bcg_pkg::*;
#(
   parameter int VOTERS  = 4,
   parameter int MAX_DIV = 15
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr,
   input  logic [1:0]            addr,
   input  logic [31:0]           wdata,
   output logic                  sw_en,
   output logic                  hw_ctl,
   output logic [CTRL_DIV_W-1:0] div_q,
   output logic                  brst_q,
   output logic [VOTERS-1:0]     vote_q,
   output logic                  div_chg
);
   localparam logic [CTRL_DIV_W-1:0] MAX_DIV_V = CTRL_DIV_W'(MAX_DIV);

   logic [CTRL_DIV_W-1:0] new_div;
   logic                  div_ok;
   logic                  ctrl_wr;
   logic                  unused_wdata;

   assign new_div      = wdata[CTRL_DIV_LSB +: CTRL_DIV_W];
   assign div_ok       = (new_div <= MAX_DIV_V);
   assign ctrl_wr      = wr && (addr == REG_CTRL);
   assign div_chg      = ctrl_wr && div_ok && (new_div != div_q);
   assign unused_wdata = ^wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sw_en  <= 1'b0;
         hw_ctl <= 1'b0;
         div_q  <= '0;
         brst_q <= 1'b0;
         vote_q <= '0;
      end else if (wr) begin
         case (addr)
            REG_CTRL: begin
               sw_en  <= wdata[CTRL_SW_BIT];
               hw_ctl <= wdata[CTRL_HW_BIT];
               if (div_ok) div_q <= new_div;
            end
            REG_BRST: brst_q <= wdata[0];
            REG_VOTE: vote_q <= wdata[VOTERS-1:0];
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/bcg_postdiv.sv
`timescale 1ns/1ps
module bcg_postdiv #(
   parameter int DIV_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ce_in,
   input  logic             gate_en,
   input  logic [DIV_W-1:0] div_val,
   input  logic             restart,
   output logic             ce_out
);
   logic [DIV_W-1:0] cnt;
   logic             bypass;
   logic             at_end;
   logic             step;

   assign bypass = (div_val == '0);
   assign at_end = (cnt == div_val);
   assign step   = ce_in && gate_en && !bypass;
   assign ce_out = ce_in && gate_en && (bypass || at_end);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt <= '0;
      else if (restart) cnt <= '0;
      else if (step)    cnt <= at_end ? '0 : cnt + 1'b1;
   end
endmodule

// File: rtl/bcg_status.sv
`timescale 1ns/1ps
module bcg_status #(
   parameter int LAT = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic force_off,
   output logic off
);
   generate
      if (LAT == 0) begin : g_direct
         assign off = !en || force_off;
      end else begin : g_pipe
         logic [LAT-1:0] pipe;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe <= '0;
            else        pipe <= (pipe << 1) | LAT'(en);
         end
         assign off = !pipe[LAT-1] || force_off;
      end
   endgenerate
endmodule

// File: rtl/bcg_branch.sv
`timescale 1ns/1ps
module bcg_branch
   import bcg_pkg::*;
#(
   parameter int                VOTERS      = 4,
   parameter logic [VOTERS-1:0] VOTE_MASK   = 4'b0111,
   parameter int                MAX_DIV     = 15,
   parameter int                STATUS_LAT  = 3
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        bus_wr,
   input  logic [1:0]  bus_addr,
   input  logic [31:0] bus_wdata,
   output logic [31:0] bus_rdata,
   input  logic        ce_in,
   input  logic        hw_req,
   output logic        ce_out,
   output logic        blk_rst_out
);
   initial begin
      if (VOTERS < 1 || VOTERS > 32) $error("VOTERS must be 1..32");
      if (MAX_DIV < 0 || MAX_DIV >= (1 << CTRL_DIV_W)) $error("MAX_DIV exceeds divider field");
      if (STATUS_LAT < 0 || STATUS_LAT > 16) $error("STATUS_LAT must be 0..16");
   end

   logic                  sw_en;
   logic                  hw_ctl;
   logic [CTRL_DIV_W-1:0] div_q;
   logic                  brst_q;
   logic [VOTERS-1:0]     vote_q;
   logic                  div_chg;
   logic                  en_eff;
   logic                  off_status;

   bcg_regs #(.VOTERS(VOTERS), .MAX_DIV(MAX_DIV)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
      .sw_en(sw_en), .hw_ctl(hw_ctl), .div_q(div_q), .brst_q(brst_q),
      .vote_q(vote_q), .div_chg(div_chg)
   );

   assign en_eff = !brst_q && (sw_en || (hw_ctl && hw_req) || ((vote_q & VOTE_MASK) != '0));

   bcg_postdiv #(.DIV_W(CTRL_DIV_W)) u_div (
      .clk(clk), .rst_n(rst_n), .ce_in(ce_in), .gate_en(en_eff),
      .div_val(div_q), .restart(div_chg), .ce_out(ce_out)
   );

   bcg_status #(.LAT(STATUS_LAT)) u_stat (
      .clk(clk), .rst_n(rst_n), .en(en_eff), .force_off(brst_q), .off(off_status)
   );

   assign blk_rst_out = brst_q;

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         REG_CTRL: begin
            bus_rdata[CTRL_SW_BIT]                      = sw_en;
            bus_rdata[CTRL_HW_BIT]                      = hw_ctl;
            bus_rdata[CTRL_DIV_LSB +: CTRL_DIV_W]       = div_q;
            bus_rdata[CTRL_OFF_BIT]                     = off_status;
         end
         REG_BRST: bus_rdata[0] = brst_q;
         REG_VOTE: bus_rdata[VOTERS-1:0] = vote_q;
         default: ;
      endcase
   end
endmodule

// File: rtl/bcg_branch_chk.sv
`timescale 1ns/1ps
module bcg_branch_chk #(
   parameter int                VOTERS     = 4,
   parameter logic [VOTERS-1:0] VOTE_MASK  = 4'b0111,
   parameter int                MAX_DIV    = 15,
   parameter int                STATUS_LAT = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic [1:0]        bus_addr,
   input logic [31:0]       bus_wdata,
   input logic              ce_in,
   input logic              ce_out,
   input logic              blk_rst_out,
   input logic              en_eff,
   input logic              off_status,
   input logic [8:0]        div_q,
   input logic [VOTERS-1:0] vote_q
);
   logic unused_chk;
   assign unused_chk = ^bus_wdata;

   assert_rst_closes_R9: assert property (@(posedge clk) disable iff (!rst_n)
      blk_rst_out |-> !ce_out);

   assert_rst_halted_R9: assert property (@(posedge clk) disable iff (!rst_n)
      blk_rst_out |-> off_status);

   assert_no_spurious_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ce_out |-> ce_in);

   assert_div_reject_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == 2'd0 && ({23'd0, bus_wdata[24:16]} > MAX_DIV)) |=> $stable(div_q));

   assert_vote_opens_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (((vote_q & VOTE_MASK) != '0) && !blk_rst_out && ce_in && div_q == 9'd0) |-> ce_out);

   generate
      if (STATUS_LAT == 3) begin : g_lat
         assert_status_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(off_status) |-> $past(en_eff, 3));
         assert_status_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(off_status) && !blk_rst_out) |-> !$past(en_eff, 3));
      end
   endgenerate
endmodule

bind bcg_branch bcg_branch_chk #(
   .VOTERS(VOTERS), .VOTE_MASK(VOTE_MASK), .MAX_DIV(MAX_DIV), .STATUS_LAT(STATUS_LAT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
   .ce_in(ce_in), .ce_out(ce_out), .blk_rst_out(blk_rst_out), .en_eff(en_eff),
   .off_status(off_status), .div_q(div_q), .vote_q(vote_q)
);

// File: tb/bcg_branch_test.sv
`timescale 1ns/1ps
module bcg_branch_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [1:0]  bus_addr = 2'd0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        ce_in = 1'b0;
   logic        hw_req = 1'b0;
   logic        ce_out;
   logic        blk_rst_out;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   bcg_branch uut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ce_in(ce_in),
      .hw_req(hw_req), .ce_out(ce_out), .blk_rst_out(blk_rst_out)
   );

   // row: {addr[1:0], data[31:0], hw_req, expected ce_out}; ce_in held 1, divider 0
   localparam int NROWS = 11;
   localparam logic [35:0] VEC [NROWS] = '{
      {2'd0, 32'h0000_0001, 1'b0, 1'b1},
      {2'd0, 32'h0000_0000, 1'b0, 1'b0},
      {2'd0, 32'h0000_0002, 1'b0, 1'b0},
      {2'd0, 32'h0000_0002, 1'b1, 1'b1},
      {2'd0, 32'h0000_0000, 1'b1, 1'b0},
      {2'd2, 32'h0000_0008, 1'b0, 1'b0},
      {2'd2, 32'h0000_0003, 1'b0, 1'b1},
      {2'd2, 32'h0000_0002, 1'b0, 1'b1},
      {2'd2, 32'h0000_0000, 1'b0, 1'b0},
      {2'd2, 32'h0000_0004, 1'b0, 1'b1},
      {2'd2, 32'h0000_0000, 1'b0, 1'b0}
   };

   task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   function automatic string row_tag(input int r);
      if (r < 2) return "R1 sw enable";
      if (r < 5) return "R2 hw control";
      return "R3 voting";
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      ce_in = 1'b1;
      // R10 reset state
      rd(2'd0, v); check(v, 32'h8000_0000, "R10 ctrl reset");
      rd(2'd1, v); check(v, 32'h0, "R10 brst reset");
      rd(2'd2, v); check(v, 32'h0, "R10 vote reset");
      check({31'd0, blk_rst_out}, 32'd0, "R10 blk_rst_out");
      check({31'd0, ce_out}, 32'd0, "R10 ce_out");

      // table walk: R1 R2 R3
      for (int r = 0; r < NROWS; r++) begin
         hw_req = VEC[r][1];
         wr(VEC[r][35:34], VEC[r][33:2]);
         #1;
         check({31'd0, ce_out}, {31'd0, VEC[r][0]}, row_tag(r));
      end
      hw_req = 1'b0;
      ce_in  = 1'b0;

      // R4 divide by 3
      wr(2'd0, 32'h0002_0001);
      ce_in = 1'b1;
      for (int i = 0; i < 6; i++) begin
         #1;
         check({31'd0, ce_out}, {31'd0, (i % 3) == 2}, "R4 divide by 3");
         @(negedge clk);
      end
      @(negedge clk);
      ce_in = 1'b0;
      // R6 restart mid-count with new divider 3
      wr(2'd0, 32'h0003_0001);
      ce_in = 1'b1;
      for (int i = 0; i < 4; i++) begin
         #1;
         check({31'd0, ce_out}, {31'd0, i == 3}, "R6 restart after change");
         @(negedge clk);
      end
      ce_in = 1'b0;

      // R5 reject oversize divider
      wr(2'd0, 32'h0010_0001);
      rd(2'd0, v); check({23'd0, v[24:16]}, 32'd3, "R5 oversize rejected");
      wr(2'd0, 32'h0010_0000);
      rd(2'd0, v); check({v[24:16], 22'd0, v[0]}, {9'd3, 23'd0}, "R5 enable bit applied");
      wr(2'd0, 32'h000F_0001);
      rd(2'd0, v); check({23'd0, v[24:16]}, 32'd15, "R5 max accepted");

      // R4 pass-through
      wr(2'd0, 32'h0000_0001);
      ce_in = 1'b1; #1;
      check({31'd0, ce_out}, 32'd1, "R4 pass high");
      ce_in = 1'b0; #1;
      check({31'd0, ce_out}, 32'd0, "R4 pass low");

      // R7 status latency
      wr(2'd0, 32'h0);
      repeat (5) @(negedge clk);
      wr(2'd0, 32'h1);
      rd(2'd0, v); check({31'd0, v[31]}, 32'd1, "R7 on +1");
      repeat (2) @(negedge clk);
      rd(2'd0, v); check({31'd0, v[31]}, 32'd1, "R7 on +3 pending");
      @(negedge clk);
      rd(2'd0, v); check({31'd0, v[31]}, 32'd0, "R7 on settled");
      wr(2'd0, 32'h0);
      rd(2'd0, v); check({31'd0, v[31]}, 32'd0, "R7 off +1");
      repeat (2) @(negedge clk);
      rd(2'd0, v); check({31'd0, v[31]}, 32'd0, "R7 off +3 pending");
      @(negedge clk);
      rd(2'd0, v); check({31'd0, v[31]}, 32'd1, "R7 off settled");

      // R8 R9 block reset
      wr(2'd0, 32'h1);
      repeat (5) @(negedge clk);
      ce_in = 1'b1;
      wr(2'd1, 32'h1);
      rd(2'd0, v);
      check({31'd0, blk_rst_out}, 32'd1, "R8 reset asserted");
      check({31'd0, ce_out}, 32'd0, "R9 gate closed");
      check({31'd0, v[31]}, 32'd1, "R9 halted at once");
      check({31'd0, v[0]}, 32'd1, "R9 ctrl kept");
      wr(2'd1, 32'h0);
      #1;
      check({31'd0, blk_rst_out}, 32'd0, "R8 reset released");
      check({31'd0, ce_out}, 32'd1, "R9 gate reopens");
      ce_in = 1'b0;

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule